// File: doc/BRIEF.md
# Serial Wiper Position Register for a Dual Potentiometer

This block is the digital control side of a dual 256-step digital potentiometer. A host drives three wires: an enable line, a serial clock and a serial data line. While the enable line is high, each rising edge of the serial clock shifts one data bit into a 17-bit frame register. The two wiper codes and the stack-select flag keep their old values throughout the shifting. They take the new frame only when the enable line falls after a proper rising edge.

The three pins are asynchronous to the block clock. They pass through two-flop synchronizers, and their edges are found by comparing registered samples. The bit that leaves the far end of the frame register is driven on a cascade output at all times. Several devices can therefore be chained on one bus: the cascade output of one device feeds the data input of the next, and the host sends one 17-bit frame per device, the frame for the farthest device first.

Top module: `tw_wiper_ctrl`

## Requirements
- R1: While `rst` is high, and on the cycle after it is released, `pot0_code` and `pot1_code` read 8'h80, and `stack_sel` and `tw_cascade` read 0.
- R2: A frame is sent first bit first. Bit one is the stack-select flag. The next eight bits are `pot1_code`, MSB first. The last eight bits are `pot0_code`, MSB first.
- R3: While a frame is being shifted, `pot0_code`, `pot1_code` and `stack_sel` do not change. They take the new frame only after `tw_en` falls.
- R4: Rising edges of `tw_sck` while `tw_en` is low leave the frame register untouched. A later enable pulse with no clocks reloads the previous frame.
- R5: Shifting and loading require a low-to-high transition of `tw_en` seen after reset. If `tw_en` is already high when reset ends, clocks are ignored and the next fall of `tw_en` loads nothing.
- R6: `wiper_pick` reads 0 when `stack_sel` is 0, meaning potentiometer 0 is selected, and reads 1 when `stack_sel` is 1, meaning potentiometer 1 is selected.
- R7: `tw_cascade` carries the bit that was shifted in 17 clocks earlier, whatever the state of `tw_en`. With two devices chained, a 34-bit write loads the first 17 bits into the far device and the last 17 bits into the near device.
- R8: A transfer of fewer than 17 bits shifts only that many bits. After the load, the wipers hold the previous frame moved along by that many positions, with the new bits at the high end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| tw_en | input | 1 | Serial enable, asynchronous |
| tw_sck | input | 1 | Serial clock; data is taken on its rising edge |
| tw_sdi | input | 1 | Serial data in |
| tw_cascade | output | 1 | Oldest bit of the frame register, for the next device in a chain |
| pot0_code | output | 8 | Wiper code of potentiometer 0 |
| pot1_code | output | 8 | Wiper code of potentiometer 1 |
| stack_sel | output | 1 | Stack-select flag |
| wiper_pick | output | 1 | Index of the potentiometer whose wiper drives the stacked output |

## Verification
The hardest state to reach from the pins is an enable line that is already high when reset ends. To get there, the bench raises `tw_en` first and only then pulses `rst`. It then clocks a full frame and drops the enable. It shows that nothing was shifted by following with a clean enable pulse that has no clocks: this pulse must load an all-zero frame, which is the post-reset register content. The two-device chain is the other hard case. It is reached by feeding the near device's cascade output into a second instance and checking both sets of wipers after one 34-bit write.

// File: rtl/twp_pkg.sv
package twp_pkg;

    localparam int unsigned WIPER_BITS = 8;

    typedef struct packed {
        logic en;
        logic sck;
        logic sdi;
    } tw_pins_t;

    typedef struct packed {
        logic en_level;
        logic en_rise;
        logic en_fall;
        logic sck_rise;
        logic sdi;
    } tw_events_t;

endpackage

// File: rtl/tw_sync.sv
module tw_sync
    import twp_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  tw_pins_t   pins_in,
    output tw_events_t ev
);
    tw_pins_t          chain [STAGES];
    tw_pins_t          prev;
    logic [STAGES:0]   warm;
    logic              valid;
    tw_pins_t          last;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
            prev <= '0;
            warm <= '0;
        end else begin
            chain[0] <= pins_in;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            prev <= chain[STAGES-1];
            warm <= {warm[STAGES-1:0], 1'b1};
        end
    end

    assign last  = chain[STAGES-1];
    assign valid = warm[STAGES];

    always_comb begin
        ev.en_level = valid & last.en;
        ev.en_rise  = valid & last.en & ~prev.en;
        ev.en_fall  = valid & ~last.en & prev.en;
        ev.sck_rise = valid & last.sck & ~prev.sck;
        ev.sdi      = last.sdi;
    end
endmodule

// File: rtl/tw_shifter.sv
module tw_shifter #(
    parameter int unsigned FRAME_W = 17
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               shift_en,
    input  logic               din,
    output logic [FRAME_W-1:0] frame,
    output logic               cascade
);
    always_ff @(posedge clk) begin
        if (rst)           frame <= '0;
        else if (shift_en) frame <= {din, frame[FRAME_W-1:1]};
    end

    assign cascade = frame[0];
endmodule

// File: rtl/tw_wiper_store.sv
module tw_wiper_store #(
    parameter int unsigned WIPER_W = 8,
    localparam int unsigned FRAME_W = 2 * WIPER_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    output logic [WIPER_W-1:0] pot0,
    output logic [WIPER_W-1:0] pot1,
    output logic               stack
);
    localparam logic [WIPER_W-1:0] MID = {1'b1, {(WIPER_W-1){1'b0}}};

    logic [WIPER_W-1:0] nxt0, nxt1;

    for (genvar k = 0; k < WIPER_W; k++) begin : g_map
        assign nxt1[WIPER_W-1-k] = frame[1 + k];
        assign nxt0[WIPER_W-1-k] = frame[1 + WIPER_W + k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pot0  <= MID;
            pot1  <= MID;
            stack <= 1'b0;
        end else if (load) begin
            pot0  <= nxt0;
            pot1  <= nxt1;
            stack <= frame[0];
        end
    end
endmodule

// File: rtl/tw_wiper_ctrl.sv
module tw_wiper_ctrl
    import twp_pkg::*;
#(
    parameter int unsigned WIPER_W     = WIPER_BITS,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tw_en,
    input  logic               tw_sck,
    input  logic               tw_sdi,
    output logic               tw_cascade,
    output logic [WIPER_W-1:0] pot0_code,
    output logic [WIPER_W-1:0] pot1_code,
    output logic               stack_sel,
    output logic               wiper_pick
);
    localparam int unsigned FRAME_W = 2 * WIPER_W + 1;

    tw_pins_t           pins;
    tw_events_t         ev;
    logic               armed;
    logic               shift_en;
    logic               load_now;
    logic [FRAME_W-1:0] frame_q;

    assign pins = '{en: tw_en, sck: tw_sck, sdi: tw_sdi};

    tw_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst(rst), .pins_in(pins), .ev(ev)
    );

    always_ff @(posedge clk) begin
        if (rst)             armed <= 1'b0;
        else if (ev.en_fall) armed <= 1'b0;
        else if (ev.en_rise) armed <= 1'b1;
    end

    assign shift_en = armed & ev.en_level & ev.sck_rise;
    assign load_now = armed & ev.en_fall;

    tw_shifter #(.FRAME_W(FRAME_W)) i_shift (
        .clk(clk), .rst(rst), .shift_en(shift_en), .din(ev.sdi),
        .frame(frame_q), .cascade(tw_cascade)
    );

    tw_wiper_store #(.WIPER_W(WIPER_W)) i_store (
        .clk(clk), .rst(rst), .load(load_now), .frame(frame_q),
        .pot0(pot0_code), .pot1(pot1_code), .stack(stack_sel)
    );

    assign wiper_pick = stack_sel;
endmodule

// File: rtl/tw_wiper_checker.sv
module tw_wiper_checker #(
    parameter int unsigned WIPER_W = 8,
    localparam int unsigned FRAME_W = 2 * WIPER_W + 1
) (
    input logic               clk,
    input logic               rst,
    input logic               en_level,
    input logic               armed,
    input logic               shift_en,
    input logic               load_now,
    input logic [FRAME_W-1:0] frame,
    input logic               cascade,
    input logic [WIPER_W-1:0] pot0,
    input logic [WIPER_W-1:0] pot1,
    input logic               stack
);
    localparam logic [WIPER_W-1:0] MID = {1'b1, {(WIPER_W-1){1'b0}}};

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    always @(posedge clk) begin
        if (rst_q === 1'b1) begin
            AST_RESET_MID: assert (pot0 == MID && pot1 == MID && !stack && !cascade) // R1
                else $error("reset values wrong");
        end
    end

    AST_HOLD_UNTIL_LOAD: assert property (@(posedge clk) disable iff (rst)
        !load_now |=> ($stable(pot0) && $stable(pot1) && $stable(stack))); // R3

    AST_IDLE_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en_level |=> $stable(frame)); // R4

    AST_UNARMED_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (!armed && !shift_en) |=> $stable(frame)); // R5

    AST_CASCADE_STEP: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> cascade == $past(frame[1])); // R7

    AST_LOAD_STACK_BIT: assert property (@(posedge clk) disable iff (rst)
        load_now |=> stack == $past(frame[0])); // R2
endmodule

bind tw_wiper_ctrl tw_wiper_checker #(.WIPER_W(WIPER_W)) i_chk (
    .clk(clk), .rst(rst), .en_level(ev.en_level), .armed(armed),
    .shift_en(shift_en), .load_now(load_now), .frame(frame_q),
    .cascade(tw_cascade), .pot0(pot0_code), .pot1(pot1_code), .stack(stack_sel)
);

// File: tb/test_tw_wiper_ctrl.sv
`timescale 1ns/1ps
module test_tw_wiper_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tw_en = 1'b0, tw_sck = 1'b0, tw_sdi = 1'b0;
    logic casc_n, casc_f;
    logic [7:0] p0_n, p1_n, p0_f, p1_f;
    logic st_n, st_f, pk_n, pk_f;

    int checks = 0;
    int errors = 0;

    logic [16:0] near_m, far_m;
    logic        armed_m;
    logic [7:0]  ep0, ep1;
    logic        est;

    always #2.5 clk = ~clk;

    tw_wiper_ctrl i_tw_wiper_ctrl (
        .clk(clk), .rst(rst), .tw_en(tw_en), .tw_sck(tw_sck), .tw_sdi(tw_sdi),
        .tw_cascade(casc_n), .pot0_code(p0_n), .pot1_code(p1_n),
        .stack_sel(st_n), .wiper_pick(pk_n)
    );

    tw_wiper_ctrl i_tw_wiper_ctrl_far (
        .clk(clk), .rst(rst), .tw_en(tw_en), .tw_sck(tw_sck), .tw_sdi(casc_n),
        .tw_cascade(casc_f), .pot0_code(p0_f), .pot1_code(p1_f),
        .stack_sel(st_f), .wiper_pick(pk_f)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        tw_sdi = b;
        tick(4);
        tw_sck = 1'b1;
        tick(6);
        tw_sck = 1'b0;
        tick(4);
        if (armed_m) begin
            far_m  = {near_m[0], far_m[16:1]};
            near_m = {b, near_m[16:1]};
        end
    endtask

    task automatic send_frame(input logic s, input logic [7:0] a1, input logic [7:0] a0);
        send_bit(s);
        for (int i = 7; i >= 0; i--) send_bit(a1[i]);
        for (int i = 7; i >= 0; i--) send_bit(a0[i]);
    endtask

    task automatic en_up;
        tw_en = 1'b1;
        tick(8);
        armed_m = 1'b1;
    endtask

    task automatic en_down;
        tw_en = 1'b0;
        tick(8);
        if (armed_m) begin
            est = near_m[0];
            for (int k = 0; k < 8; k++) begin
                ep1[7-k] = near_m[1+k];
                ep0[7-k] = near_m[9+k];
            end
        end
        armed_m = 1'b0;
    endtask

    task automatic check_near(input string tag);
        check({tag, " pot0"}, 32'(p0_n), 32'(ep0));
        check({tag, " pot1"}, 32'(p1_n), 32'(ep1));
        check({tag, " stack"}, 32'(st_n), 32'(est));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] a0, a1;
        logic       s;
        near_m = '0; far_m = '0; armed_m = 1'b0;
        ep0 = 8'h80; ep1 = 8'h80; est = 1'b0;

        // R1: reset state
        tick(5);
        check_near("R1 in reset");
        check("R1 cascade", 32'(casc_n), 32'd0);
        rst = 1'b0;
        tick(1);
        check_near("R1 after release");
        tick(5);

        // R2, R3, R6: sweep of all pot1 codes with varied pot0 and stack bit
        for (int i = 0; i < 256; i++) begin
            a1 = 8'(i);
            a0 = 8'((i * 37 + 11) & 255);
            s  = a1[2] ^ a1[5];
            en_up;
            send_frame(s, a1, a0);
            check("R3 hold during shift", {15'd0, p1_n, p0_n, st_n}, {15'd0, ep1, ep0, est});
            en_down;
            check("R2 pot1", 32'(p1_n), 32'(a1));
            check("R2 pot0", 32'(p0_n), 32'(a0));
            check("R2 stack", 32'(st_n), 32'(s));
            check("R6 pick", 32'(pk_n), 32'(s));
        end

        // R4: clocks with enable low are ignored
        for (int i = 0; i < 6; i++) send_bit(1'(i % 2));
        en_up;
        en_down;
        check_near("R4 reload unchanged frame");

        // R8: short transfer moves the frame by five places
        en_up;
        send_bit(1); send_bit(0); send_bit(1); send_bit(1); send_bit(0);
        en_down;
        check_near("R8 partial frame");

        // R5: enable already high when reset ends
        tw_en = 1'b1;
        tick(8);
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(8);
        near_m = '0; far_m = '0; armed_m = 1'b0;
        ep0 = 8'h80; ep1 = 8'h80; est = 1'b0;
        send_frame(1'b1, 8'h3C, 8'hA5);
        tw_en = 1'b0;
        tick(8);
        check_near("R5 no load without rise");
        en_up;
        en_down;
        check_near("R5 register untouched");
        check("R5 pot1 zero", 32'(p1_n), 32'd0);

        // R7: two devices chained, 34-bit write, cascade tracked per bit
        en_up;
        send_frame(1'b1, 8'hC3, 8'h5A);
        check("R7 cascade after first frame", 32'(casc_n), 32'(near_m[0]));
        send_frame(1'b0, 8'h96, 8'h0F);
        check("R7 cascade after second frame", 32'(casc_n), 32'(near_m[0]));
        en_down;
        check("R7 near pot1", 32'(p1_n), 32'h96);
        check("R7 near pot0", 32'(p0_n), 32'h0F);
        check("R7 near stack", 32'(st_n), 32'd0);
        check("R7 far pot1", 32'(p1_f), 32'hC3);
        check("R7 far pot0", 32'(p0_f), 32'h5A);
        check("R7 far stack", 32'(st_f), 32'd1);
        check("R6 far pick", 32'(pk_f), 32'd1);
        check("R7 far model", {7'd0, p1_f, p0_f, st_f},
              {7'd0, far_m[1], far_m[2], far_m[3], far_m[4], far_m[5], far_m[6], far_m[7], far_m[8],
               far_m[9], far_m[10], far_m[11], far_m[12], far_m[13], far_m[14], far_m[15], far_m[16],
               far_m[0]});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule